// File: doc/BRIEF.md
# Fetch-Driven Execution Privilege Controller

This block decides, cycle by cycle, whether the processor is running privileged firmware or an unprivileged application. Software has no way to set the level. The block watches every instruction-fetch address and switches level on its own. Privilege drops when execution moves out of the boot ROM into higher memory. Privilege returns only when the processor calls a single registered syscall entry point.

Next to the level, the block keeps three further pieces of state. The first is a ROM execute permission. The processor loses it when it leaves ROM and gets it back only through the syscall entry or the hash-routine entry. The second is a one-way lock that hides the sensitive assets from the first real entry into application level onward. The third is a sticky halt, raised by a fetch that must not happen. Firmware programs the two entry addresses through a small write port. Both entries reset to an address outside the fetchable map, so calling one before it is programmed halts the processor.

Top module: `exec_priv_ctrl`

## Requirements
- R1: During and right after reset, the level is firmware (`mode_app`=0), `rom_exec_en`=1, `asset_en`=1, `spi_en`=1 and `halt`=0.
- R2: A valid fetch at a mapped address at or above `ROM_BYTES` that is not the syscall entry sets `mode_app`=1 on the next cycle.
- R3: A valid fetch whose address equals the syscall entry register exactly, on every bit, sets `mode_app`=0 on the next cycle.
- R4: Writes on the configuration port never change `mode_app`, `rom_exec_en` or `asset_en`. `cfg_sel`=0 selects the syscall entry and `cfg_sel`=1 selects the hash entry. A fetch compares against the register value held before a write in the same cycle.
- R5: Both entry registers reset to all ones, which lies at or above `MAP_TOP`. A fetch there before programming raises `halt`.
- R6: A valid fetch at or above `ROM_BYTES` that hits neither entry clears `rom_exec_en` on the next cycle.
- R7: A fetch that hits the syscall entry, or the hash entry compared with address bits [1:0] ignored, sets `rom_exec_en` on the next cycle.
- R8: `asset_en` falls on the cycle after the first entry into application level. It stays low until reset, and a return to firmware level does not raise it.
- R9: Entry-register writes and firmware-level fetches inside ROM leave `asset_en` high.
- R10: `spi_en` is high exactly when `mode_app` is low.
- R11: `halt` rises on the cycle after a valid fetch at or above `MAP_TOP`, or after a ROM fetch made while `rom_exec_en`=0 that hits no entry. It stays high until reset, and while it is high no other state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | ADDR_W | Instruction fetch byte address |
| cfg_we | input | 1 | Entry register write enable |
| cfg_sel | input | 1 | 0 = syscall entry, 1 = hash entry |
| cfg_wdata | input | ADDR_W | Entry address to store |
| mode_app | output | 1 | 1 = application level, 0 = firmware level |
| rom_exec_en | output | 1 | ROM may be executed |
| asset_en | output | 1 | Sensitive assets accessible |
| spi_en | output | 1 | SPI master accessible |
| halt | output | 1 | Illegal fetch seen, sticky until reset |

## Verification
The bench builds the block with `ADDR_W`=16, `ROM_BYTES`=0x100 and `MAP_TOP`=0x4000. With a map this small, random fetches land often in each address class: ROM, mapped RAM, unmapped space, exact entry hits, and hash hits with nonzero low bits. Many short episodes reach every combination of level, ROM permission and lock state, as well as the halt path. Directed sequences cover fetches before programming, the lock surviving a syscall return, and writes made in the same cycle as a fetch.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic {
        MODE_FW  = 1'b0,
        MODE_APP = 1'b1
    } priv_mode_e;

    typedef enum logic {
        ENT_SYSCALL = 1'b0,
        ENT_HASH    = 1'b1
    } entry_sel_e;

    localparam int unsigned NUM_ENTRIES = 2;

    // Classification of one fetch address
    typedef struct packed {
        logic unmapped;
        logic in_rom;
        logic sys_hit;
        logic hash_hit;
    } fetch_class_t;

    // Architectural state of the controller
    typedef struct packed {
        priv_mode_e mode;
        logic       rom_x;
        logic       locked;
        logic       halted;
    } priv_state_t;

    localparam priv_state_t STATE_RESET = '{
        mode:   MODE_FW,
        rom_x:  1'b1,
        locked: 1'b0,
        halted: 1'b0
    };

    function automatic priv_state_t next_state(priv_state_t cur, logic valid,
                                               fetch_class_t fc);
        priv_state_t nx;
        nx = cur;
        if (!cur.halted && valid) begin
            if (fc.unmapped) begin
                nx.halted = 1'b1;
            end else if (fc.in_rom && !cur.rom_x && !fc.sys_hit && !fc.hash_hit) begin
                nx.halted = 1'b1;
            end else begin
                if (fc.sys_hit) begin
                    nx.mode = MODE_FW;
                end else if (!fc.in_rom) begin
                    nx.mode = MODE_APP;
                end
                if (fc.sys_hit || fc.hash_hit) begin
                    nx.rom_x = 1'b1;
                end else if (!fc.in_rom) begin
                    nx.rom_x = 1'b0;
                end
                if (nx.mode == MODE_APP) begin
                    nx.locked = 1'b1;
                end
            end
        end
        return nx;
    endfunction

endpackage

// File: rtl/priv_entry_regs.sv
module priv_entry_regs
    import priv_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] sys_entry,
    output logic [ADDR_W-1:0] hash_entry
);

    logic [ADDR_W-1:0] entry_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '1;
            end else if (cfg_we && (32'(cfg_sel) == g)) begin
                entry_q[g] <= cfg_wdata;
            end
        end
    end

    assign sys_entry  = entry_q[int'(ENT_SYSCALL)];
    assign hash_entry = entry_q[int'(ENT_HASH)];

endmodule

// File: rtl/priv_fetch_classify.sv
module priv_fetch_classify
    import priv_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ROM_BYTES = 32'h0000_2000,
    parameter int unsigned MAP_TOP   = 32'h4002_0000
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] sys_entry,
    input  logic [ADDR_W-1:0] hash_entry,
    output fetch_class_t      fclass
);

    localparam logic [ADDR_W-1:0] ROM_END   = ADDR_W'(ROM_BYTES);
    localparam logic [ADDR_W-1:0] MAP_END   = ADDR_W'(MAP_TOP);
    localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

    always_comb begin
        fclass.unmapped = (fetch_addr >= MAP_END);
        fclass.in_rom   = (fetch_addr < ROM_END);
        fclass.sys_hit  = (fetch_addr == sys_entry);
        fclass.hash_hit = ((fetch_addr & WORD_MASK) == (hash_entry & WORD_MASK));
    end

endmodule

// File: rtl/priv_state_reg.sv
module priv_state_reg
    import priv_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         fetch_valid,
    input  fetch_class_t fclass,
    output priv_state_t  state
);

    priv_state_t state_d;

    always_comb begin
        state_d = next_state(state, fetch_valid, fclass);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= STATE_RESET;
        end else begin
            state <= state_d;
        end
    end

endmodule

// File: rtl/exec_priv_ctrl.sv
module exec_priv_ctrl
    import priv_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ROM_BYTES = 32'h0000_2000,
    parameter int unsigned MAP_TOP   = 32'h4002_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic              mode_app,
    output logic              rom_exec_en,
    output logic              asset_en,
    output logic              spi_en,
    output logic              halt
);

    logic [ADDR_W-1:0] sys_entry;
    logic [ADDR_W-1:0] hash_entry;
    fetch_class_t      fclass;
    priv_state_t       state;

    priv_entry_regs #(.ADDR_W(ADDR_W)) u_entries (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .sys_entry  (sys_entry),
        .hash_entry (hash_entry)
    );

    priv_fetch_classify #(
        .ADDR_W    (ADDR_W),
        .ROM_BYTES (ROM_BYTES),
        .MAP_TOP   (MAP_TOP)
    ) u_classify (
        .fetch_addr (fetch_addr),
        .sys_entry  (sys_entry),
        .hash_entry (hash_entry),
        .fclass     (fclass)
    );

    priv_state_reg u_state (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fclass      (fclass),
        .state       (state)
    );

    assign mode_app    = (state.mode == MODE_APP);
    assign rom_exec_en = state.rom_x;
    assign asset_en    = !state.locked;
    assign spi_en      = (state.mode == MODE_FW);
    assign halt        = state.halted;

endmodule

// File: rtl/exec_priv_ctrl_chk.sv
module exec_priv_ctrl_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned ROM_BYTES = 32'h0000_2000,
    parameter int unsigned MAP_TOP   = 32'h4002_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] sys_entry,
    input logic              mode_app,
    input logic              rom_exec_en,
    input logic              asset_en,
    input logic              spi_en,
    input logic              halt
);

    localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(ROM_BYTES);
    localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(MAP_TOP);

    logic ram_fetch;
    logic sys_fetch;
    assign ram_fetch = fetch_valid && !halt && fetch_addr >= ROM_END &&
                       fetch_addr < MAP_END && fetch_addr != sys_entry;
    assign sys_fetch = fetch_valid && !halt && fetch_addr == sys_entry &&
                       fetch_addr < MAP_END && (rom_exec_en || fetch_addr >= ROM_END);

    // R2
    app_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ram_fetch |=> mode_app);

    // R3
    syscall_return_chk: assert property (@(posedge clk) disable iff (rst)
        sys_fetch |=> !mode_app);

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !asset_en |=> !asset_en);

    // R8
    lock_follows_app_chk: assert property (@(posedge clk) disable iff (rst)
        mode_app |-> !asset_en);

    // R10
    spi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        spi_en != mode_app);

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt && $stable(mode_app) && $stable(rom_exec_en) && $stable(asset_en));

    // R11
    unmapped_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_addr >= MAP_END) |=> halt);

endmodule

bind exec_priv_ctrl exec_priv_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .ROM_BYTES (ROM_BYTES),
    .MAP_TOP   (MAP_TOP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .sys_entry   (sys_entry),
    .mode_app    (mode_app),
    .rom_exec_en (rom_exec_en),
    .asset_en    (asset_en),
    .spi_en      (spi_en),
    .halt        (halt)
);

// File: tb/exec_priv_ctrl_tb.sv
`timescale 1ns/1ps
module exec_priv_ctrl_tb;

    localparam int unsigned AW   = 16;
    localparam int unsigned ROMB = 16'h0100;
    localparam int unsigned MAPT = 16'h4000;
    localparam logic [AW-1:0] SYS_A  = 16'h0040;
    localparam logic [AW-1:0] HASH_A = 16'h0080;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fv = 1'b0;
    logic [AW-1:0] fa = '0;
    logic          we = 1'b0;
    logic          sel = 1'b0;
    logic [AW-1:0] wd = '0;
    logic          mode_app, rom_exec_en, asset_en, spi_en, halt;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic          m_app, m_rx, m_lock, m_halt;
    logic [AW-1:0] m_sys, m_hash;

    always #4 clk = ~clk;

    exec_priv_ctrl #(.ADDR_W(AW), .ROM_BYTES(ROMB), .MAP_TOP(MAPT)) u_dut (
        .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_addr(fa),
        .cfg_we(we), .cfg_sel(sel), .cfg_wdata(wd),
        .mode_app(mode_app), .rom_exec_en(rom_exec_en), .asset_en(asset_en),
        .spi_en(spi_en), .halt(halt)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        check(req, "mode_app", mode_app, m_app);
        check(req, "rom_exec_en", rom_exec_en, m_rx);
        check(req, "asset_en", asset_en, !m_lock);
        check("R10", "spi_en", spi_en, !m_app);
        check(req, "halt", halt, m_halt);
    endtask

    task automatic model_reset();
        m_app = 1'b0; m_rx = 1'b1; m_lock = 1'b0; m_halt = 1'b0;
        m_sys = '1; m_hash = '1;
    endtask

    // Model of R2, R3, R5, R6, R7, R8, R11 plus R4 write timing
    task automatic model_step(logic v, logic [AW-1:0] a, logic w, logic s,
                              logic [AW-1:0] d);
        logic unm, inr, sh, hh;
        unm = (32'(a) >= MAPT);
        inr = (32'(a) < ROMB);
        sh  = (a == m_sys);
        hh  = (a[AW-1:2] == m_hash[AW-1:2]);
        if (!m_halt && v) begin
            if (unm || (inr && !m_rx && !sh && !hh)) begin
                m_halt = 1'b1;
            end else begin
                if (sh) m_app = 1'b0;
                else if (!inr) m_app = 1'b1;
                if (sh || hh) m_rx = 1'b1;
                else if (!inr) m_rx = 1'b0;
                if (m_app) m_lock = 1'b1;
            end
        end
        if (w) begin
            if (s) m_hash = d;
            else m_sys = d;
        end
    endtask

    // drive at negedge, check at next negedge after the capturing edge
    task automatic cycle(string req, logic v, logic [AW-1:0] a, logic w, logic s,
                         logic [AW-1:0] d);
        fv = v; fa = a; we = w; sel = s; wd = d;
        model_step(v, a, w, s, d);
        @(negedge clk);
        fv = 1'b0; we = 1'b0;
        check_all(req);
    endtask

    task automatic do_reset();
        rst = 1'b1; fv = 1'b0; we = 1'b0;
        model_reset();
        @(negedge clk);
        check_all("R1");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic program_entries();
        cycle("R4", 1'b0, '0, 1'b1, 1'b0, SYS_A);
        cycle("R4", 1'b0, '0, 1'b1, 1'b1, HASH_A);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        @(negedge clk);

        // R5: calling an unprogrammed syscall entry halts
        do_reset();
        cycle("R5", 1'b1, 16'hFFFF, 1'b0, 1'b0, '0);
        check("R5", "halt after unprogrammed call", halt, 1'b1);
        cycle("R11", 1'b1, SYS_A, 1'b0, 1'b0, '0);

        // R9, R4: firmware ROM fetches and writes leave lock clear
        do_reset();
        program_entries();
        cycle("R9", 1'b1, 16'h0010, 1'b0, 1'b0, '0);
        cycle("R9", 1'b1, 16'h00FC, 1'b1, 1'b0, SYS_A);
        check("R9", "asset_en in firmware ROM", asset_en, 1'b1);

        // R2, R8, R3, R6, R7: leave ROM, syscall back, lock survives
        cycle("R2", 1'b1, 16'h0100, 1'b0, 1'b0, '0);
        check("R8", "asset locked after app entry", asset_en, 1'b0);
        check("R6", "rom_x cleared", rom_exec_en, 1'b0);
        cycle("R3", 1'b1, SYS_A, 1'b0, 1'b0, '0);
        check("R3", "firmware after syscall", mode_app, 1'b0);
        check("R8", "lock survives syscall", asset_en, 1'b0);
        cycle("R6", 1'b1, 16'h1234, 1'b0, 1'b0, '0);
        cycle("R7", 1'b1, HASH_A + 16'd3, 1'b0, 1'b0, '0);
        check("R7", "hash hit with low bits", rom_exec_en, 1'b1);
        cycle("R11", 1'b1, 16'h2000, 1'b0, 1'b0, '0);
        cycle("R11", 1'b1, 16'h0004, 1'b0, 1'b0, '0);
        check("R11", "rom fetch without permission", halt, 1'b1);

        // R4: write during a fetch uses the old entry value
        do_reset();
        program_entries();
        cycle("R2", 1'b1, 16'h0200, 1'b0, 1'b0, '0);
        cycle("R4", 1'b1, 16'h0300, 1'b1, 1'b0, 16'h0300);
        cycle("R3", 1'b1, 16'h0300, 1'b0, 1'b0, '0);

        // random episodes over address classes
        lfsr = 16'hACE1;
        for (int ep = 0; ep < 40; ep++) begin
            do_reset();
            if (ep % 4 != 0) program_entries();
            for (int c = 0; c < 300; c++) begin
                logic [AW-1:0] a;
                logic v, w;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v = 1'b1; w = 1'b0;
                case (lfsr[2:0])
                    3'd0: a = {8'h00, lfsr[15:8]};
                    3'd1: a = m_sys;
                    3'd2: a = {m_hash[AW-1:2], lfsr[9:8]};
                    3'd3, 3'd4: a = 16'h0100 + {3'b000, lfsr[15:3]} % 16'h3F00;
                    3'd5: a = (lfsr[10:6] == 5'd0) ? {2'b01, lfsr[15:2]} : {8'h00, lfsr[15:8]};
                    3'd6: begin a = 16'h0100; v = 1'b0; end
                    default: begin a = {8'h00, lfsr[15:8]}; w = 1'b1; end
                endcase
                cycle("R2", v, a, w, lfsr[11],
                      lfsr[11] ? HASH_A : SYS_A);
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule